// File: doc/BRIEF.md
# Linear array pixel readout sequencer

This block sequences the readout of a 64-element linear light sensor. A start strobe sampled on a rising clock edge launches a single token into a chain of one stage per pixel. Each following rising edge moves the token one stage on, and the stage that holds it selects the pixel that drives the shared output. Once the token leaves the last stage, the chain is empty and the block is idle, ready for the next start.

Alongside the one-hot select and a binary pixel number, the block produces the control strobes the analog path needs: an output enable that is high only while a pixel is presented, so several sensors can share one output line; a sample strobe that follows the high phase of the clock; and a sense-node reset strobe in the low phase of every readout cycle. The analog path is stood in for by a mux that presents the stored digital code of the selected pixel.

A readout occupies 64 output cycles, and a 65th edge returns the chain to idle. The earliest restart is therefore on the 66th edge, which gives back-to-back readouts with the shortest integration interval.

Top module: `lin_readout_seq`

## Requirements
- R1: While rst_ni is low (asynchronously), sel_o, pix_idx_o, oe_o, pix_data_o, samp_o and sns_rst_o are all zero.
- R2: At most one bit of sel_o is high. Bit k (k = 0..63) high means pixel k+1 is selected.
- R3: When the block is idle and start_i is high at a rising edge, after that edge sel_o[0] = 1, pix_idx_o = 1 and oe_o = 1.
- R4: Each later rising edge moves the selection up by one pixel. After the k-th edge of a readout (counting the start edge as the 1st), pix_idx_o = k for k = 1..64. When idle, pix_idx_o = 0.
- R5: The 65th edge of a readout clears sel_o, drops oe_o and returns pix_idx_o to 0.
- R6: start_i is ignored on edges 2 to 65 of a readout. No second token enters, and the sequence continues unchanged.
- R7: start_i high on the 66th edge begins a new readout at once, with pix_idx_o = 1 after that edge.
- R8: oe_o stays high for exactly 64 consecutive clock cycles per uninterrupted readout and is low at all other times.
- R9: pix_data_o equals the code of the selected pixel. Pixel p (1..64) takes bits [(p-1)*CODE_W +: CODE_W] of pix_code_i. pix_data_o is 0 when oe_o is low.
- R10: During a readout, samp_o = 1 while clk_i is high and sns_rst_o = 1 while clk_i is low. Both are 0 when idle, and they are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock, rising edge active |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Serial start strobe into the token chain |
| pix_code_i | input | N_PIX*CODE_W | Stored pixel codes, pixel 1 in the low field |
| sel_o | output | N_PIX | One-hot pixel select |
| pix_idx_o | output | $clog2(N_PIX+1) | Selected pixel number 1..64, 0 when idle |
| oe_o | output | 1 | Output enable; low means the output is released |
| pix_data_o | output | CODE_W | Code of the selected pixel |
| samp_o | output | 1 | Sample strobe (high clock phase) |
| sns_rst_o | output | 1 | Sense-node reset strobe (low clock phase) |

## Verification
A behavioural position model is compared on every cycle against several kinds of start pattern. A single pulse shows the basic 1-to-64 walk and the 65th-edge release. Pulses inside a readout, including one on the 65th edge itself, show that no second token appears. A pulse on exactly the 66th edge and a start held high for several hundred cycles show that back-to-back restart works without a gap cycle. A reset in the middle of a readout, followed by a change of the pixel code pattern, separates the asynchronous clear from the mux path.

// File: rtl/lrs_pkg.sv
package lrs_pkg;
  function automatic int idx_width(input int n);
    return $clog2(n + 1);
  endfunction
endpackage

// File: rtl/lrs_token_chain.sv
module lrs_token_chain #(
  parameter int N = 64
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  output logic [N-1:0] sel_o,
  output logic         busy_o
);
  logic [N-1:0] sr_q;

  assign busy_o = |sr_q;
  assign sel_o  = sr_q;

  // a start is only taken once the previous token has left the chain
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '0;
    else         sr_q <= {sr_q[N-2:0], start_i & ~busy_o};
  end

  assert_start_take_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> sr_q[0]);

  assert_start_ignore_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> !sr_q[0]);

  assert_release_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sr_q[N-1] |=> (sr_q[N-1:1] == '0));

  for (genvar k = 0; k < N-1; k++) begin : g_adv
    assert_advance_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sr_q[k] |=> sr_q[k+1]);
  end
endmodule

// File: rtl/lrs_idx_enc.sv
module lrs_idx_enc #(
  parameter int N = 64,
  parameter int W = 7
) (
  input  logic [N-1:0] sel_i,
  output logic [W-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int k = 0; k < N; k++) begin
      if (sel_i[k]) idx_o = idx_o | W'(k + 1);
    end
  end
endmodule

// File: rtl/lrs_pix_mux.sv
module lrs_pix_mux #(
  parameter int N = 64,
  parameter int W = 8
) (
  input  logic [N-1:0]   sel_i,
  input  logic [N*W-1:0] code_i,
  output logic [W-1:0]   data_o
);
  always_comb begin
    data_o = '0;
    for (int k = 0; k < N; k++) begin
      if (sel_i[k]) data_o = data_o | code_i[k*W +: W];
    end
  end
endmodule

// File: rtl/lrs_strobe.sv
module lrs_strobe (
  input  logic clk_i,
  input  logic busy_i,
  output logic samp_o,
  output logic sns_rst_o
);
  // phases of the pixel clock split sample and sense-node reset
  assign samp_o    = busy_i & clk_i;
  assign sns_rst_o = busy_i & ~clk_i;

  always_comb begin
    assert_no_overlap_R10: assert (!(samp_o && sns_rst_o));
  end
endmodule

// File: rtl/lin_readout_seq.sv
module lin_readout_seq #(
  parameter int N_PIX  = 64,
  parameter int CODE_W = 8,
  localparam int IDX_W = lrs_pkg::idx_width(N_PIX)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    start_i,
  input  logic [N_PIX*CODE_W-1:0] pix_code_i,
  output logic [N_PIX-1:0]        sel_o,
  output logic [IDX_W-1:0]        pix_idx_o,
  output logic                    oe_o,
  output logic [CODE_W-1:0]       pix_data_o,
  output logic                    samp_o,
  output logic                    sns_rst_o
);
  logic busy;

  lrs_token_chain #(.N(N_PIX)) u_chain (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i),
    .sel_o(sel_o), .busy_o(busy)
  );

  lrs_idx_enc #(.N(N_PIX), .W(IDX_W)) u_enc (
    .sel_i(sel_o), .idx_o(pix_idx_o)
  );

  lrs_pix_mux #(.N(N_PIX), .W(CODE_W)) u_mux (
    .sel_i(sel_o), .code_i(pix_code_i), .data_o(pix_data_o)
  );

  lrs_strobe u_strobe (
    .clk_i(clk_i), .busy_i(busy), .samp_o(samp_o), .sns_rst_o(sns_rst_o)
  );

  assign oe_o = busy;

  // window length checker
  logic [IDX_W-1:0] run_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   run_q <= '0;
    else if (oe_o) run_q <= run_q + 1'b1;
    else           run_q <= '0;
  end

  assert_onehot_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(sel_o));

  assert_first_pix_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(oe_o) |-> (pix_idx_o == IDX_W'(1)));

  assert_window_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(oe_o) |-> (run_q == IDX_W'(N_PIX)));

  assert_idle_data_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_o |-> (pix_data_o == '0 && pix_idx_o == '0));
endmodule

// File: tb/lin_readout_seq_test.sv
`timescale 1ns/1ps
module lin_readout_seq_test;
  localparam int N = 64;
  localparam int CW = 8;
  localparam int IW = $clog2(N + 1);

  logic clk = 0, rst_ni = 0, start_i = 0;
  logic [N*CW-1:0] pix_code;
  logic [N-1:0] sel_o;
  logic [IW-1:0] pix_idx_o;
  logic oe_o, samp_o, sns_rst_o;
  logic [CW-1:0] pix_data_o;

  int n_run = 0, n_fail = 0;
  int pos = 0;
  int pat = 0;
  int oe_cnt = 0;
  bit oe_abort = 0;

  always #10 clk = ~clk;

  lin_readout_seq #(.N_PIX(N), .CODE_W(CW)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .pix_code_i(pix_code),
    .sel_o(sel_o), .pix_idx_o(pix_idx_o), .oe_o(oe_o), .pix_data_o(pix_data_o),
    .samp_o(samp_o), .sns_rst_o(sns_rst_o)
  );

  function automatic logic [CW-1:0] code_of(input int k, input int p);
    return (p == 0) ? CW'((k * 37 + 5) & 255) : CW'((k ^ 8'hA5) & 255);
  endfunction

  task automatic load_codes(input int p);
    pat = p;
    for (int k = 0; k < N; k++) pix_code[k*CW +: CW] = code_of(k, p);
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model: position 0 = idle, 1..N = pixel shown
  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) pos <= 0;
    else if (pos == N + 0 && pos != 0) pos <= 0;
    else if (pos > 0) pos <= pos + 1;
    else if (start_i) pos <= 1;
  end

  always @(negedge rst_ni) oe_abort = 1;

  // high-phase check
  always @(posedge clk) begin
    #5;
    chk(samp_o == (pos != 0), "R10 samp high phase", samp_o, pos != 0);
    chk(sns_rst_o == 1'b0, "R10 sns_rst high phase", sns_rst_o, 0);
  end

  // low-phase check of everything
  always @(negedge clk) begin
    logic [N-1:0] exp_sel;
    exp_sel = (pos == 0) ? '0 : (N'(1) << (pos - 1));
    chk(sel_o == exp_sel, "R2 sel", int'(pix_idx_o), pos);
    chk(int'(pix_idx_o) == pos, "R4 idx", int'(pix_idx_o), pos);
    chk(oe_o == (pos != 0), "R8 oe", oe_o, pos != 0);
    chk(int'(pix_data_o) == ((pos == 0) ? 0 : int'(code_of(pos - 1, pat))),
        "R9 data", pix_data_o, (pos == 0) ? 0 : int'(code_of(pos - 1, pat)));
    chk(sns_rst_o == (pos != 0), "R10 sns_rst low phase", sns_rst_o, pos != 0);
    chk(samp_o == 1'b0, "R10 samp low phase", samp_o, 0);
    if (oe_o) oe_cnt++;
    else begin
      if (oe_cnt != 0 && !oe_abort) chk(oe_cnt == N, "R8 window", oe_cnt, N);
      oe_cnt = 0;
      oe_abort = 0;
    end
  end

  task automatic edge_s(input bit s);
    start_i = s;
    @(posedge clk);
    #3;
  endtask

  initial begin
    load_codes(0);
    repeat (2) edge_s(0);
    chk(sel_o == '0 && oe_o == 0, "R1 reset sel/oe", oe_o, 0);
    chk(pix_idx_o == '0 && pix_data_o == '0, "R1 reset idx/data", pix_idx_o, 0);
    rst_ni = 1;
    repeat (3) edge_s(0);

    // single pulse
    edge_s(1);
    chk(pix_idx_o == 1 && oe_o && sel_o[0], "R3 first pixel", pix_idx_o, 1);
    for (int k = 2; k <= N; k++) edge_s(0);
    chk(pix_idx_o == IW'(N), "R4 last pixel", pix_idx_o, N);
    edge_s(0);
    chk(pix_idx_o == 0 && !oe_o && sel_o == '0, "R5 release", pix_idx_o, 0);
    repeat (4) edge_s(0);

    // pulses inside a readout, one on the 65th edge
    edge_s(1);
    edge_s(1);
    chk(pix_idx_o == 2 && $countones(sel_o) == 1, "R6 start on edge 2", pix_idx_o, 2);
    for (int k = 3; k <= 40; k++) edge_s(k == 30);
    chk(pix_idx_o == 40, "R6 mid pulse", pix_idx_o, 40);
    for (int k = 41; k <= N; k++) edge_s(0);
    edge_s(1);
    chk(pix_idx_o == 0 && !oe_o, "R6 start on edge 65", pix_idx_o, 0);
    edge_s(0);
    chk(pix_idx_o == 0, "R6 no late token", pix_idx_o, 0);
    repeat (3) edge_s(0);

    // start on exactly edge 66
    edge_s(1);
    for (int k = 2; k <= N + 1; k++) edge_s(0);
    edge_s(1);
    chk(pix_idx_o == 1 && oe_o, "R7 back to back", pix_idx_o, 1);
    for (int k = 2; k <= 20; k++) edge_s(0);

    // reset mid-readout
    rst_ni = 0;
    #1;
    chk(sel_o == '0 && !oe_o && pix_idx_o == '0, "R1 async clear", pix_idx_o, 0);
    chk(samp_o == 0 && sns_rst_o == 0 && pix_data_o == '0, "R1 strobes clear", samp_o, 0);
    edge_s(1);
    chk(pix_idx_o == 0, "R1 start held in reset", pix_idx_o, 0);
    rst_ni = 1;
    load_codes(1);
    edge_s(0);

    // start held high: continuous readouts
    for (int k = 0; k < 3 * (N + 1) + 5; k++) edge_s(1);
    edge_s(0);
    repeat (N + 3) edge_s(0);
    chk(pix_idx_o == 0 && !oe_o, "R5 idle after run", pix_idx_o, 0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(20 * 100000);
    n_run++;
    n_fail++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule